// File: doc/BRIEF.md
# Least-Frequently-Used Way Selector with Carried Set Count

This block picks the way to refill in one set of a set-associative cache whose replacement rule is least-frequently-used. It keeps a saturating reference count and a valid flag for each way of each set. It also keeps one carried count per set. The surrounding cache controller does the tag compare and holds the data. It reports each lookup as a request strobe with the set index, a hit flag and, on a hit, the way that matched.

A hit adds one to the matching way's count, and the block gives no output for it. A miss starts a short sequence in a three-state machine. `ST_IDLE` takes the request and moves to `ST_PICK`. `ST_PICK` chooses the way and writes the counts, then moves to `ST_DONE`. `ST_DONE` raises the strobe for one cycle and returns to `ST_IDLE`. Ways that have never been filled are used before any valid way is replaced. When a valid way has to be replaced, its count moves into the set's carried register, and the refilled way starts from that carried value plus one. A line brought in after a long-lived line was evicted therefore does not begin at the bottom of the ranking.

Top module: `lfu_repl`

## Requirements
- R1: After reset every way is invalid, every way count and every carried count is zero, and `sel_valid` is low.
- R2: A miss request (`req_valid`=1, `req_hit`=0) sampled in `ST_IDLE` at clock edge k gives `sel_valid`=1 only between edges k+1 and k+2, for exactly one cycle. `sel_way` holds the chosen way while `sel_valid` is high.
- R3: If the set has an invalid way, the lowest-numbered invalid way is chosen.
- R4: If every way of the set is valid, the way with the smallest count is chosen, and a tie goes to the lowest way index.
- R5: A hit request (`req_hit`=1) sampled in `ST_IDLE` adds one to the count of way `req_hit_way` in set `req_set`. The count saturates at 2^CNT_W-1, and a hit raises no `sel_valid`.
- R6: When a valid way is replaced, the set's carried count takes that way's count. The way's new count is that carried value plus one, saturating.
- R7: When an invalid way is filled, it becomes valid and its count becomes the set's carried count plus one. The carried count is left unchanged.
- R8: Any request presented while the machine is in `ST_PICK` or `ST_DONE` is ignored and changes no count.
- R9: The counts, valid flags and carried count of one set are never changed by requests to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup result strobe |
| req_set | input | SET_W | Set index of the lookup |
| req_hit | input | 1 | 1 = hit, 0 = miss |
| req_hit_way | input | WAY_W | Way that hit (used only when req_hit=1) |
| sel_valid | output | 1 | One-cycle strobe: sel_way is the way to refill |
| sel_way | output | WAY_W | Chosen way for the last miss |

## Verification
The first fills of each set walk through the ways from the bottom and show the order in which invalid ways are used. Tied counts across a full set show that a tie goes to the lowest index, and this is kept apart from a simple round-robin rule. A way hit more often than the count can hold must stay the most-used way, which separates saturating counts from counts that wrap. A miss that carries stray hits during its busy cycles, followed by a second miss on the same set, shows whether those hits were dropped and whether the replaced way came back at the carried count plus one. A long pseudo-random run of hits and misses over all sets is then compared with an arithmetic model kept in the bench.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_DONE = 2'd2
    } lfu_state_e;
endpackage

// File: rtl/lfu_store.sv
module lfu_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int CNT_W = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             hit_en,
    input  logic [SET_W-1:0]                 hit_set,
    input  logic [WAY_W-1:0]                 hit_way,
    input  logic                             fill_en,
    input  logic                             fill_evict,
    input  logic [SET_W-1:0]                 fill_set,
    input  logic [WAY_W-1:0]                 fill_way,
    input  logic [SET_W-1:0]                 rd_set,
    output logic [WAYS-1:0]                  rd_valid,
    output logic [WAYS-1:0][CNT_W-1:0]       rd_cnt,
    output logic [CNT_W-1:0]                 rd_carry
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [WAYS-1:0]            vld_q   [SETS];
    logic [WAYS-1:0][CNT_W-1:0] cnt_q   [SETS];
    logic [CNT_W-1:0]           carry_q [SETS];

    logic [CNT_W-1:0] fill_base;
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] hit_old;

    // an evicted way hands its count to the set before restarting from it
    always_comb begin
        fill_base = fill_evict ? cnt_q[fill_set][fill_way] : carry_q[fill_set];
        fill_cnt  = (fill_base == CMAX) ? CMAX : fill_base + 1'b1;
        hit_old   = cnt_q[hit_set][hit_way];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]   <= '0;
                cnt_q[s]   <= '0;
                carry_q[s] <= '0;
            end
        end else begin
            if (hit_en && (hit_old != CMAX))
                cnt_q[hit_set][hit_way] <= hit_old + 1'b1;
            if (fill_en) begin
                vld_q[fill_set][fill_way] <= 1'b1;
                cnt_q[fill_set][fill_way] <= fill_cnt;
                if (fill_evict)
                    carry_q[fill_set] <= cnt_q[fill_set][fill_way];
            end
        end
    end

    always_comb begin
        rd_valid = vld_q[rd_set];
        rd_cnt   = cnt_q[rd_set];
        rd_carry = carry_q[rd_set];
    end
endmodule

// File: rtl/lfu_pick.sv
module lfu_pick #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][CNT_W-1:0] cnt,
    output logic                       inv_found,
    output logic [WAY_W-1:0]           way,
    output logic [CNT_W-1:0]           min_cnt
);
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] min_way;

    // scanning downward leaves the lowest invalid index
    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
    end

    // strict less-than keeps the lowest index on ties
    always_comb begin
        min_way = '0;
        min_cnt = cnt[0];
        for (int w = 1; w < WAYS; w++) begin
            if (cnt[w] < min_cnt) begin
                min_cnt = cnt[w];
                min_way = WAY_W'(w);
            end
        end
    end

    assign way = inv_found ? inv_way : min_way;
endmodule

// File: rtl/lfu_repl.sv
module lfu_repl #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int CNT_W = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_set,
    input  logic             req_hit,
    input  logic [WAY_W-1:0] req_hit_way,
    output logic             sel_valid,
    output logic [WAY_W-1:0] sel_way
);
    import lfu_pkg::*;

    lfu_state_e state_q, state_d;
    logic [SET_W-1:0] set_q;
    logic [WAY_W-1:0] way_q;

    logic                       hit_en;
    logic                       miss_take;
    logic [WAYS-1:0]            rd_valid;
    logic [WAYS-1:0][CNT_W-1:0] rd_cnt;
    logic [CNT_W-1:0]           rd_carry;
    logic                       pk_inv;
    logic [WAY_W-1:0]           pk_way;
    logic [CNT_W-1:0]           pk_cnt;

    assign hit_en    = (state_q == ST_IDLE) && req_valid && req_hit;
    assign miss_take = (state_q == ST_IDLE) && req_valid && !req_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (miss_take) state_d = ST_PICK;
            ST_PICK: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            set_q   <= '0;
            way_q   <= '0;
        end else begin
            state_q <= state_d;
            if (miss_take)
                set_q <= req_set;
            if (state_q == ST_PICK)
                way_q <= pk_way;
        end
    end

    always_comb begin
        sel_valid = (state_q == ST_DONE);
        sel_way   = way_q;
    end

    lfu_store #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_en     (hit_en),
        .hit_set    (req_set),
        .hit_way    (req_hit_way),
        .fill_en    (state_q == ST_PICK),
        .fill_evict (!pk_inv),
        .fill_set   (set_q),
        .fill_way   (pk_way),
        .rd_set     (set_q),
        .rd_valid   (rd_valid),
        .rd_cnt     (rd_cnt),
        .rd_carry   (rd_carry)
    );

    lfu_pick #(.WAYS(WAYS), .CNT_W(CNT_W)) u_pick (
        .valid     (rd_valid),
        .cnt       (rd_cnt),
        .inv_found (pk_inv),
        .way       (pk_way),
        .min_cnt   (pk_cnt)
    );
endmodule

// File: rtl/lfu_repl_chk.sv
module lfu_repl_chk #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_hit,
    input logic                 sel_valid,
    input lfu_pkg::lfu_state_e  state_q,
    input logic [WAYS-1:0]      rd_valid,
    input logic                 pk_inv,
    input logic [WAY_W-1:0]     pk_way,
    input logic [CNT_W-1:0]     pk_cnt,
    input logic [CNT_W-1:0]     rd_carry
);
    import lfu_pkg::*;

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> !sel_valid);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && !req_hit) |=> (!sel_valid ##1 sel_valid));

    a_r3_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICK && !(&rd_valid)) |-> !rd_valid[pk_way]);

    a_r6_carry_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICK && !pk_inv) |=> (rd_carry == $past(pk_cnt)));

    a_r7_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICK && pk_inv) |=> $stable(rd_carry));
endmodule

bind lfu_repl lfu_repl_chk #(.WAYS(WAYS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_hit   (req_hit),
    .sel_valid (sel_valid),
    .state_q   (state_q),
    .rd_valid  (rd_valid),
    .pk_inv    (pk_inv),
    .pk_way    (pk_way),
    .pk_cnt    (pk_cnt),
    .rd_carry  (rd_carry)
);

// File: tb/sim_lfu_repl.sv
module sim_lfu_repl;
    localparam int WAYS  = 4;
    localparam int SETS  = 4;
    localparam int CNT_W = 3;
    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [SET_W-1:0] req_set = '0;
    logic             req_hit = 1'b0;
    logic [WAY_W-1:0] req_hit_way = '0;
    logic             sel_valid;
    logic [WAY_W-1:0] sel_way;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    int m_vld [SETS][WAYS];
    int m_cnt [SETS][WAYS];
    int m_car [SETS];

    always #5 clk = ~clk;

    lfu_repl #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_set     (req_set),
        .req_hit     (req_hit),
        .req_hit_way (req_hit_way),
        .sel_valid   (sel_valid),
        .sel_way     (sel_way)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_pick(input int s);
        int best = 0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (m_vld[s][w] == 0) best = w;
        for (int w = 0; w < WAYS; w++)
            if (m_vld[s][w] == 0) return best;
        best = 0;
        for (int w = 1; w < WAYS; w++)
            if (m_cnt[s][w] < m_cnt[s][best]) best = w;
        return best;
    endfunction

    task automatic do_hit(input int s, input int w);
        @(negedge clk);
        req_valid = 1'b1; req_hit = 1'b1;
        req_set = SET_W'(s); req_hit_way = WAY_W'(w);
        @(negedge clk);
        req_valid = 1'b0;
        check(sel_valid == 1'b0, "R5 hit gives no strobe", int'(sel_valid), 0);
        if (m_cnt[s][w] < CMAX) m_cnt[s][w]++;
    endtask

    task automatic do_miss(input int s, input bit junk, input string tag);
        int exp;
        int base;
        exp = m_pick(s);
        @(negedge clk);
        req_valid = 1'b1; req_hit = 1'b0; req_set = SET_W'(s);
        @(negedge clk);
        check(sel_valid == 1'b0, "R2 no strobe one cycle after miss", int'(sel_valid), 0);
        if (junk) begin
            // R8: stray hits during the busy cycles
            req_valid = 1'b1; req_hit = 1'b1; req_hit_way = '0;
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        check(sel_valid == 1'b1, "R2 strobe two cycles after miss", int'(sel_valid), 1);
        check(int'(sel_way) == exp, tag, int'(sel_way), exp);
        @(negedge clk);
        req_valid = 1'b0; req_hit = 1'b0;
        check(sel_valid == 1'b0, "R2 strobe lasts one cycle", int'(sel_valid), 0);
        if (m_vld[s][exp] != 0) m_car[s] = m_cnt[s][exp];
        base = m_car[s];
        m_cnt[s][exp] = (base + 1 > CMAX) ? CMAX : base + 1;
        m_vld[s][exp] = 1;
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int s = 0; s < SETS; s++) begin
            m_car[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 0;
                m_cnt[s][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        check(sel_valid == 1'b0, "R1 strobe low in reset", int'(sel_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sel_valid == 1'b0, "R1 strobe low after reset", int'(sel_valid), 0);

        // R3 / R7: invalid ways of every set fill from way 0 upward
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                do_miss(s, 1'b0, "R3 lowest invalid way first");

        // R4: set 0 all counts 1, tie goes to way 0; then carry makes way 0 count 2
        do_miss(0, 1'b0, "R4 tie picks lowest way");
        do_miss(0, 1'b0, "R6 evicted way restarts at carry plus one");

        // R8: set 1, way 0 least used; stray hits on way 0 while busy must not count
        for (int w = 1; w < WAYS; w++) do_hit(1, w);
        do_miss(1, 1'b1, "R8 victim before busy hits");
        do_miss(1, 1'b0, "R8 busy hits ignored");

        // R5: saturation in set 2; way 0 hit 9 times would wrap to 2 with 3 bits
        for (int k = 0; k < 9; k++) do_hit(2, 0);
        for (int w = 1; w < WAYS; w++)
            for (int k = 0; k < 3; k++) do_hit(2, w);
        do_miss(2, 1'b0, "R5 saturated count stays high");

        // R9: set 3 untouched so far beyond fills, all counts 1 -> way 0
        do_miss(3, 1'b0, "R9 other sets untouched");

        // sweep: pseudo-random mix over all sets against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            int s;
            int w;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = int'(lfsr[1:0]) % SETS;
            w = int'(lfsr[5:4]) % WAYS;
            if (lfsr[8:6] != 3'd0 && m_vld[s][w] != 0)
                do_hit(s, w);
            else
                do_miss(s, lfsr[9], "R4 R6 R9 sweep victim");
        end

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule